// File: doc/BRIEF.md
# Four-Level Interrupt Mask and Status Unit

This unit sits beside one processor core and gathers external interrupt requests into four priority levels, named level 2 to level 5, with 32 request lines per level. Each cycle it samples every request line into a status register. It combines the status with a per-level mask and drives one interrupt line per level to the core. A mask bit of 1 blocks its source. Software never writes the mask directly. It sets mask bits through one register and clears them through another, so two agents can change different bits without a read-modify-write race.

Software reaches the unit through a simple register bus. There is a write strobe and a read strobe, and each access moves one 32-bit word. A read returns its data one cycle after the strobe. The bus, the source vector and the interrupt outputs are plain control and status pins. None of them carries a stream, so no valid/ready handshake and no back-pressure apply. The bus can take one access every cycle. A dedicated doorbell input from the neighbouring cores is folded into one fixed position of the lowest level.

Top module: `irq_mask_ctrl`

## Requirements
- R1: Each level owns a 16-byte window. Level 2 starts at 0x00, level 3 at 0x10, level 4 at 0x20 and level 5 at 0x30. Inside a window, word offset 0x0 is the set register, 0x4 the clear register, 0x8 the mask and 0xC the status. The set and clear registers read as zero. An access with address bits [1:0] not equal to zero does nothing.
- R2: Bit 0 of `irq_out` belongs to level 2 and bit 3 to level 5. Bit n of `irq_out` is high exactly when at least one status bit of that level is 1 and its mask bit is 0.
- R3: A write to a set register forces every mask bit whose data bit is 1 to 1. Mask bits whose data bit is 0 keep their value.
- R4: A write to a clear register forces every mask bit whose data bit is 1 to 0. Mask bits whose data bit is 0 keep their value.
- R5: Each status bit equals its source line as sampled at the previous clock edge. A status bit therefore falls once its source is released.
- R6: Writes to a mask register or a status register change no state.
- R7: During and after reset, every mask bit is 1, every status bit is 0, `irq_out` is 0 and `bus_rdata` is 0.
- R8: While `db_req` is high, bit 8 of level 2 is treated as a raised source, in addition to `src_vec` bit 8.
- R9: `bus_rdata` takes the addressed value at the clock edge where `bus_rd` is high. It keeps that value until the next read.
- R10: A mask write and a source change that meet at the same clock edge both take effect at that edge. `irq_out` then reflects both of them together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 6 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| src_vec | input | 128 | Request lines; bits [32n+31:32n] feed level n+2 |
| db_req | input | 1 | Doorbell request from other cores |
| irq_out | output | 4 | One interrupt line per level, bit 0 = level 2 |

## Verification
A register write that unmasks or masks a bit can land on the same clock edge at which that bit's source line rises or falls. The bench provokes this deliberately in both directions. It drives a clear write together with a rising source, and a set write together with a falling source. It compares `irq_out` at the following half cycle against a model that applies both changes at once. It also checks `irq_out` before the edge, so that a design which lets one change lead or lag the other by a cycle is caught.

// File: rtl/irq_mask_pkg.sv
package irq_mask_pkg;
  typedef enum logic [1:0] {
    SEL_SET  = 2'd0,
    SEL_CLR  = 2'd1,
    SEL_MASK = 2'd2,
    SEL_STAT = 2'd3
  } reg_sel_e;

  localparam int WIN_BITS = 4;
endpackage

// File: rtl/irq_mask_level.sv
module irq_mask_level #(
  parameter int SRC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_stb,
  input  logic             clr_stb,
  input  logic [SRC_W-1:0] wbits,
  input  logic [SRC_W-1:0] src,
  output logic [SRC_W-1:0] mask_o,
  output logic [SRC_W-1:0] stat_o,
  output logic             irq_o
);
  logic [SRC_W-1:0] mask_q;
  logic [SRC_W-1:0] stat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
      stat_q <= '0;
    end else begin
      stat_q <= src;
      if (set_stb)      mask_q <= mask_q | wbits;
      else if (clr_stb) mask_q <= mask_q & ~wbits;
    end
  end

  assign mask_o = mask_q;
  assign stat_o = stat_q;
  assign irq_o  = |(stat_q & ~mask_q);

  AST_SET_FORCES_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    set_stb |=> ((mask_q & $past(wbits)) == $past(wbits))); // R3
  AST_SET_KEEPS_REST: assert property (@(posedge clk) disable iff (!rst_n)
    set_stb |=> ((mask_q & ~$past(wbits)) == ($past(mask_q) & ~$past(wbits)))); // R3
  AST_CLR_FORCES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_stb && !set_stb) |=> ((mask_q & $past(wbits)) == '0)); // R4
  AST_MASK_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_stb && !clr_stb) |=> (mask_q == $past(mask_q))); // R6
  AST_STATUS_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (stat_q == $past(src))); // R5
  AST_FULL_MASK_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '1) |-> !irq_o); // R2
  AST_NO_STATUS_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q == '0) |-> !irq_o); // R2
endmodule

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
  import irq_mask_pkg::*;
#(
  parameter int NLVL  = 4,
  parameter int SRC_W = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        bus_wr,
  input  logic                        bus_rd,
  input  logic [$clog2(NLVL)+3:0]     bus_addr,
  input  logic [NLVL-1:0][SRC_W-1:0]  mask_i,
  input  logic [NLVL-1:0][SRC_W-1:0]  stat_i,
  output logic [NLVL-1:0]             set_stb,
  output logic [NLVL-1:0]             clr_stb,
  output logic [SRC_W-1:0]            rdata
);
  localparam int LW = $clog2(NLVL);

  logic [LW-1:0]    lvl;
  reg_sel_e         sel;
  logic             hit;
  logic [SRC_W-1:0] rd_next;

  assign lvl = bus_addr[WIN_BITS+LW-1:WIN_BITS];
  assign sel = reg_sel_e'(bus_addr[3:2]);
  assign hit = (bus_addr[1:0] == 2'b00) && (int'(lvl) < NLVL);

  for (genvar g = 0; g < NLVL; g++) begin : g_strobe
    assign set_stb[g] = bus_wr && hit && (int'(lvl) == g) && (sel == SEL_SET);
    assign clr_stb[g] = bus_wr && hit && (int'(lvl) == g) && (sel == SEL_CLR);
  end

  always_comb begin
    rd_next = '0;
    if (hit) begin
      case (sel)
        SEL_MASK: rd_next = mask_i[lvl];
        SEL_STAT: rd_next = stat_i[lvl];
        default:  rd_next = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata <= '0;
    else if (bus_rd) rdata <= rd_next;
  end

  AST_ONE_LEVEL_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(set_stb | clr_stb)); // R1
  AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(rdata)); // R9
endmodule

// File: rtl/irq_mask_ctrl.sv
module irq_mask_ctrl #(
  parameter int NLVL   = 4,
  parameter int SRC_W  = 32,
  parameter int DB_BIT = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bus_wr,
  input  logic                    bus_rd,
  input  logic [$clog2(NLVL)+3:0] bus_addr,
  input  logic [SRC_W-1:0]        bus_wdata,
  output logic [SRC_W-1:0]        bus_rdata,
  input  logic [NLVL*SRC_W-1:0]   src_vec,
  input  logic                    db_req,
  output logic [NLVL-1:0]         irq_out
);
  logic [NLVL-1:0][SRC_W-1:0] mask_w;
  logic [NLVL-1:0][SRC_W-1:0] stat_w;
  logic [NLVL-1:0][SRC_W-1:0] src_eff;
  logic [NLVL-1:0]            set_stb;
  logic [NLVL-1:0]            clr_stb;
  logic [SRC_W-1:0]           db_bits;

  assign db_bits = db_req ? (SRC_W'(1) << DB_BIT) : '0;

  irq_reg_decode #(.NLVL(NLVL), .SRC_W(SRC_W)) u_dec (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .bus_addr (bus_addr),
    .mask_i   (mask_w),
    .stat_i   (stat_w),
    .set_stb  (set_stb),
    .clr_stb  (clr_stb),
    .rdata    (bus_rdata)
  );

  for (genvar g = 0; g < NLVL; g++) begin : g_lvl
    if (g == 0) begin : g_db
      assign src_eff[g] = src_vec[g*SRC_W +: SRC_W] | db_bits;
    end else begin : g_plain
      assign src_eff[g] = src_vec[g*SRC_W +: SRC_W];
    end

    irq_mask_level #(.SRC_W(SRC_W)) u_lvl (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_stb (set_stb[g]),
      .clr_stb (clr_stb[g]),
      .wbits   (bus_wdata),
      .src     (src_eff[g]),
      .mask_o  (mask_w[g]),
      .stat_o  (stat_w[g]),
      .irq_o   (irq_out[g])
    );
  end

  AST_DOORBELL_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    db_req |=> stat_w[0][DB_BIT]); // R8
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |-> (irq_out == '0 && bus_rdata == '0)); // R7
endmodule

// File: tb/sim_irq_mask_ctrl.sv
`timescale 1ns/1ps
module sim_irq_mask_ctrl;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         bus_wr = 1'b0;
  logic         bus_rd = 1'b0;
  logic [5:0]   bus_addr = '0;
  logic [31:0]  bus_wdata = '0;
  logic [31:0]  bus_rdata;
  logic [127:0] src_vec = '0;
  logic         db_req = 1'b0;
  logic [3:0]   irq_out;

  int n_chk = 0;
  int n_fail = 0;

  logic [31:0] m_mask [4];
  logic [31:0] m_src  [4];
  logic        m_db;

  always #2.5 clk = ~clk;

  irq_mask_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .src_vec(src_vec), .db_req(db_req), .irq_out(irq_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_stat(input int l);
    return m_src[l] | ((l == 0 && m_db) ? 32'h0000_0100 : 32'h0);
  endfunction

  function automatic logic [3:0] exp_irq();
    logic [3:0] r;
    for (int l = 0; l < 4; l++) r[l] = |(exp_stat(l) & ~m_mask[l]);
    return r;
  endfunction

  task automatic bus_write(input int l, input int off, input logic [31:0] d);
    @(negedge clk);
    bus_addr = 6'(l*16 + off); bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    if (off == 0) m_mask[l] = m_mask[l] | d;
    if (off == 4) m_mask[l] = m_mask[l] & ~d;
  endtask

  task automatic bus_read(input int l, input int off, output logic [31:0] d);
    @(negedge clk);
    bus_addr = 6'(l*16 + off); bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic drive_src();
    @(negedge clk);
    src_vec = {m_src[3], m_src[2], m_src[1], m_src[0]};
    db_req = m_db;
    @(negedge clk);
  endtask

  task automatic check_all(input string req);
    logic [31:0] d;
    chk({req, " irq"}, 32'(irq_out), 32'(exp_irq()));
    for (int l = 0; l < 4; l++) begin
      bus_read(l, 8, d);
      chk({req, " mask"}, d, m_mask[l]);
      bus_read(l, 12, d);
      chk({req, " status"}, d, exp_stat(l));
    end
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    for (int l = 0; l < 4; l++) begin m_mask[l] = '1; m_src[l] = '0; end
    m_db = 1'b0;
    #12;
    chk("R7 irq in reset", 32'(irq_out), 32'h0);
    chk("R7 rdata in reset", bus_rdata, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    check_all("R7");

    // R1: set and clear windows read as zero; misaligned access ignored
    for (int l = 0; l < 4; l++) begin
      bus_read(l, 0, d); chk("R1 set reads zero", d, 32'h0);
      bus_read(l, 4, d); chk("R1 clear reads zero", d, 32'h0);
    end
    @(negedge clk);
    bus_addr = 6'h05; bus_wdata = '1; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
    check_all("R1 misaligned");

    // R2: all sources up, all masked -> quiet
    for (int l = 0; l < 4; l++) m_src[l] = '1;
    drive_src();
    check_all("R2 masked");

    // R5: distinct patterns per level
    m_src[0] = 32'hA5A5_0F0F; m_src[1] = 32'h0000_8001;
    m_src[2] = 32'h1234_5678; m_src[3] = 32'h0000_0000;
    drive_src();
    check_all("R5 pattern");

    // R4 then R3: sweep every bit of every level
    for (int l = 0; l < 4; l++)
      for (int b = 0; b < 32; b++) begin
        bus_write(l, 4, 32'h1 << b);
        chk("R4 irq", 32'(irq_out), 32'(exp_irq()));
        chk("R2 irq", 32'(irq_out[l]), 32'(|(exp_stat(l) & ~m_mask[l])));
      end
    check_all("R4 sweep");
    for (int l = 0; l < 4; l++)
      for (int b = 31; b >= 0; b--) begin
        bus_write(l, 0, 32'h1 << b);
        chk("R3 irq", 32'(irq_out), 32'(exp_irq()));
      end
    check_all("R3 sweep");

    // R3/R4: multi-bit patterns leave zero bits alone
    bus_write(2, 4, 32'hFF00_FF00); check_all("R4 multi");
    bus_write(2, 0, 32'h0F00_0000); check_all("R3 multi");
    bus_write(2, 4, 32'h0000_0000); check_all("R4 zero data");

    // R5: release sources, status falls
    m_src[2] = 32'h0;
    drive_src();
    check_all("R5 release");

    // R6: writes to mask and status change nothing
    for (int l = 0; l < 4; l++) begin
      bus_write(l, 8, ~m_mask[l]);
      bus_write(l, 12, 32'hFFFF_FFFF);
    end
    check_all("R6");

    // R8: doorbell into level 2 bit 8
    m_src[0] = 32'h0;
    drive_src();
    bus_write(0, 4, 32'h0000_0100);
    chk("R8 idle", 32'(irq_out[0]), 32'h0);
    m_db = 1'b1;
    drive_src();
    check_all("R8 doorbell");
    m_db = 1'b0;
    drive_src();
    check_all("R8 release");

    // R9: rdata holds across writes and idle cycles
    bus_read(1, 8, d);
    bus_write(1, 4, 32'h0000_0001);
    @(negedge clk);
    chk("R9 hold", bus_rdata, d);

    // R10: clear write meets rising source in the same edge
    m_src[3] = 32'h0;
    drive_src();
    bus_write(3, 0, '1);
    @(negedge clk);
    chk("R10 before", 32'(irq_out[3]), 32'h0);
    bus_addr = 6'h34; bus_wdata = 32'h0000_0040; bus_wr = 1'b1;
    m_src[3] = 32'h0000_0040;
    src_vec = {m_src[3], m_src[2], m_src[1], m_src[0]};
    m_mask[3] = m_mask[3] & ~32'h0000_0040;
    @(negedge clk); bus_wr = 1'b0;
    chk("R10 unmask+rise", 32'(irq_out), 32'(exp_irq()));
    // set write meets falling source in the same edge
    bus_addr = 6'h30; bus_wdata = 32'h0000_0040; bus_wr = 1'b1;
    m_src[3] = 32'h0;
    src_vec = {m_src[3], m_src[2], m_src[1], m_src[0]};
    m_mask[3] = m_mask[3] | 32'h0000_0040;
    @(negedge clk); bus_wr = 1'b0;
    chk("R10 mask+fall", 32'(irq_out), 32'(exp_irq()));
    check_all("R10");

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule